// File: doc/BRIEF.md
# Gated 22 kHz Tone Generator and Supply Path Selector

This block drives the signalling side of one LNB supply port. A free-running oscillator, divided down from the system clock, produces a square wave near 22 kHz. A gate decides whether the wave reaches the output. The gate either stays open all the time (continuous mode) or follows a keying data pin, so that bursts of tone carry pulse-width keyed data. The gate opens and closes only at the start of a high half-period. As a result, every tone pulse that leaves the block is a whole half-period long.

The same control word picks the active supply path. The transmit path carries both supply and tone. The receive path carries supply only. A global enable switches everything off. Two control bits form a 2-bit level code that tells the analog regulator which output voltage to produce. The keying pin passes through a two-flop synchroniser, so it may come from another clock domain.

Top module: `tone_gate`

## Requirements
- R1: While reset is held, and after it is released with all controls low, `tone_out`, `tx_en` and `rx_en` are 0 and `lvl` is 2'b00.
- R2: When `en` is 0, the edge after it is sampled sets `tx_en`, `rx_en` and `tone_out` to 0 and `lvl` to 2'b00, whatever the other inputs are.
- R3: With `en`=1, `ttx`=1 gives `tx_en`=1 and `rx_en`=0, and `ttx`=0 gives `rx_en`=1 and `tx_en`=0, one clock after the inputs are sampled. The two paths are never on together.
- R4: With `en`=1, `lvl` equals {`vsel`,`llc`} one clock later. The codes mean: 2'b00 is 13.25 V, 2'b01 is 14.25 V, 2'b10 is 18 V and 2'b11 is 19.5 V.
- R5: With `en`=`ttx`=`ten`=1, `tone_out` is a square wave that is high for HALF_DIV cycles and low for HALF_DIV cycles, and `dsq_in` has no effect on it.
- R6: With `en`=`ttx`=1 and `ten`=0, `tone_out` stays 0 once `dsq_in` has been low for 2*HALF_DIV+4 cycles. Once `dsq_in` has been high for 2*HALF_DIV+4 cycles, at least one tone pulse has started.
- R7: While the transmit path stays enabled, every high pulse of `tone_out` lasts exactly HALF_DIV cycles, however `dsq_in` or `ten` move (no runt pulses).
- R8: `tone_out` is 0 whenever `tx_en` is 0. Turning the transmit path off stops a running pulse one clock after the change is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dsq_in | input | 1 | Asynchronous keying data; tone is wanted while high |
| en | input | 1 | Global enable for the supply port |
| ten | input | 1 | Continuous tone, keying pin ignored |
| ttx | input | 1 | 1 selects the transmit path, 0 the receive path |
| vsel | input | 1 | High-voltage select (level code MSB) |
| llc | input | 1 | Cable-loss boost (level code LSB) |
| tone_out | output | 1 | Gated tone waveform |
| tx_en | output | 1 | Transmit path enable (supply plus tone) |
| rx_en | output | 1 | Receive path enable (supply only) |
| lvl | output | 2 | Regulator level code |

## Verification
Two actions can land in the same cycle: the keying pin can change while a tone half-period is ending, and the transmit path can be switched off while a pulse is running. The bench toggles `dsq_in` at random moments, with hold times both shorter and longer than a tone period. It then measures every complete high run of `tone_out` and judges each one against HALF_DIV. It also drops `ttx` in the middle of a pulse and checks that the tone is cut on the very next clock. A separate random sweep over the control bits checks the path and level outputs against a model in the bench.

// File: rtl/tone_gate.sv
module tone_gate #(
  parameter int HALF_DIV = 23
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dsq_in,
  input  logic       en,
  input  logic       ten,
  input  logic       ttx,
  input  logic       vsel,
  input  logic       llc,
  output logic       tone_out,
  output logic       tx_en,
  output logic       rx_en,
  output logic [1:0] lvl
);

  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam int RW = $clog2(HALF_DIV + 1) + 1;

  logic [CW-1:0] div_cnt;
  logic          phase;
  logic          dsq_meta, dsq_sync;
  logic          gate;

  wire tick    = (div_cnt == CW'(HALF_DIV - 1));
  wire path_on = en & ttx;
  wire want    = path_on & (ten | dsq_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      phase   <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) phase <= ~phase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dsq_meta <= 1'b0;
      dsq_sync <= 1'b0;
    end else begin
      dsq_meta <= dsq_in;
      dsq_sync <= dsq_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 gate <= 1'b0;
    else if (!path_on)       gate <= 1'b0;
    else if (tick && !phase) gate <= want;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      lvl   <= 2'b00;
    end else begin
      tx_en <= en & ttx;
      rx_en <= en & ~ttx;
      lvl   <= en ? {vsel, llc} : 2'b00;
    end
  end

  assign tone_out = gate & phase;

  logic [RW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)           hi_run <= '0;
    else if (tone_out) hi_run <= hi_run + 1'b1;
    else               hi_run <= '0;
  end

  // R3
  path_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_en && rx_en));

  // R2
  off_all_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tx_en && !rx_en && !tone_out && lvl == 2'b00));

  // R4
  level_map_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (lvl == $past({vsel, llc})));

  // R8
  tone_tx_only_chk: assert property (@(posedge clk) disable iff (rst)
    tone_out |-> tx_en);

  // R7
  no_long_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tone_out |-> (hi_run < RW'(HALF_DIV)));

  // R7
  full_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(tone_out) && tx_en) |-> (hi_run == RW'(HALF_DIV)));

endmodule

// File: tb/tone_gate_tb.sv
module tone_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 23;
  localparam int SETTLE = 2 * H + 4;

  logic clk = 1'b0, rst = 1'b1;
  logic dsq_in = 0, en = 0, ten = 0, ttx = 0, vsel = 0, llc = 0;
  logic tone_out, tx_en, rx_en;
  logic [1:0] lvl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_gate #(.HALF_DIV(H)) u_dut (
    .clk(clk), .rst(rst), .dsq_in(dsq_in), .en(en), .ten(ten), .ttx(ttx),
    .vsel(vsel), .llc(llc), .tone_out(tone_out), .tx_en(tx_en),
    .rx_en(rx_en), .lvl(lvl));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic e, t, v, l);
    logic [1:0] lv;
    lv = e ? {v, l} : 2'b00;
    return {e & t, e & ~t, lv, 1'b0};
  endfunction

  task automatic observe(input int n, input bit gated);
    bit prev, seen_edge, pulsed;
    int run, hi_age, lo_age, hold;
    prev = tone_out; seen_edge = 0; run = 0; pulsed = 0;
    hi_age = 0; lo_age = 0; hold = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tone_out == prev) run++;
      else begin
        if (seen_edge) begin
          if (prev) check(run == H, "R7 high run", run, H);
          else if (!gated) check(run == H, "R5 low run", run, H);
        end
        seen_edge = 1; run = 1; prev = tone_out;
      end
      if (tone_out) pulsed = 1;
      if (gated) begin
        if (!dsq_in && lo_age >= SETTLE) check(tone_out == 0, "R6 gated off", tone_out, 0);
        if (dsq_in && hi_age == SETTLE) check(pulsed, "R6 start", pulsed, 1);
      end
      if (hold == 0) begin
        hold = gated ? $urandom_range(150, 5) : $urandom_range(9, 1);
        dsq_in = ~dsq_in;
        if (dsq_in) begin hi_age = 0; pulsed = 0; end else lo_age = 0;
      end else begin
        hold--;
        if (dsq_in) hi_age++; else lo_age++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] e;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 during reset
    check({tone_out, tx_en, rx_en, lvl} == 5'b0, "R1 in reset", {tone_out, tx_en, rx_en, lvl}, 0);
    rst = 0;
    @(negedge clk);
    check({tone_out, tx_en, rx_en, lvl} == 5'b0, "R1 after reset", {tone_out, tx_en, rx_en, lvl}, 0);

    // R2 R3 R4 random sweep of control bits
    for (int i = 0; i < 60; i++) begin
      en = $urandom_range(1, 0); ttx = $urandom_range(1, 0);
      vsel = $urandom_range(1, 0); llc = $urandom_range(1, 0);
      ten = $urandom_range(1, 0); dsq_in = $urandom_range(1, 0);
      e = model(en, ttx, vsel, llc);
      @(negedge clk);
      check({tx_en, rx_en} == e[4:3], "R3 path", {tx_en, rx_en}, e[4:3]);
      check(lvl == e[2:1], "R4 level", lvl, e[2:1]);
      if (!en) check(tone_out == 0, "R2 tone off", tone_out, 0);
    end

    // R4 directed corners
    en = 1; ttx = 1;
    for (int c = 0; c < 4; c++) begin
      {vsel, llc} = 2'(c);
      @(negedge clk);
      check(lvl == 2'(c), "R4 code", lvl, c);
    end

    // R5 continuous mode, dsq toggled (ignored)
    ten = 1;
    observe(2000, 0);

    // R6 R7 gated mode with random keying
    ten = 0; dsq_in = 0;
    observe(6000, 1);

    // R3 receive path carries no tone
    ten = 1; ttx = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3 * H; i++) begin
      @(negedge clk);
      if (i % H == 0) begin
        check(tone_out == 0, "R3 rx no tone", tone_out, 0);
        check(rx_en && !tx_en, "R3 rx path", {tx_en, rx_en}, 1);
      end
    end

    // R8 cut a running pulse
    ttx = 1;
    while (!tone_out) @(negedge clk);
    repeat (3) @(negedge clk);
    ttx = 0;
    @(negedge clk);
    check(tone_out == 0, "R8 cut", tone_out, 0);
    check(tx_en == 0, "R8 tx off", tx_en, 0);

    // R2 enable off with everything else on
    ttx = 1; vsel = 1; llc = 1;
    while (!tone_out) @(negedge clk);
    en = 0;
    @(negedge clk);
    check({tone_out, tx_en, rx_en, lvl} == 5'b0, "R2 disable", {tone_out, tx_en, rx_en, lvl}, 0);
    for (int i = 0; i < 4 * H; i++) begin
      @(negedge clk);
      if (tone_out) check(0, "R2 tone while off", tone_out, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule